// File: doc/BRIEF.md
# JTAG TAP Passive Bus Monitor

This block watches the four wires of an IEEE 1149.1 test access port (test clock, mode select, data in, data out) without driving any of them. It oversamples the pins with its own system clock, finds each rising edge of the test clock, and follows the sixteen-state TAP controller from the mode-select value seen at that edge. On every new state it gives a one-cycle report that carries the state code.

While the controller stays in a Shift state, the monitor gathers the data-in and data-out bits into two vectors. When the scan ends with the move into Exit1, it gives a one-cycle scan report. The report carries both vectors, an instruction/data tag, the bit count and an overflow flag. A trace unit or an on-chip debug logger takes these reports and stores or filters them.

Both report outputs are valid-only streams. There is no ready input, because a passive observer cannot stall the bus it watches. The consumer must take every pulse in the cycle it appears. A new report can come no sooner than one test-clock period later, which is at least four system cycles.

Top module: `tap_watch`

## Requirements
- R1: Synchronous active-high `rst` puts the tracked state at Run-Test/Idle (code 1), clears both collectors and holds `st_vld` and `scan_vld` low. The first rising test-clock edge after reset moves the state but gives no state report.
- R2: Each rising test-clock edge moves the state by the standard TAP rules, using the mode-select value sampled at that edge. The state codes are 0 Test-Logic-Reset, 1 Run-Test/Idle, 2 Select-DR, 3 Capture-DR, 4 Update-DR, 5 Pause-DR, 6 Shift-DR, 7 Exit1-DR, 8 Exit2-DR, 9 Select-IR, 10 Capture-IR, 11 Update-IR, 12 Pause-IR, 13 Shift-IR, 14 Exit1-IR and 15 Exit2-IR.
- R3: Every rising edge other than the first after reset gives exactly one single-cycle `st_vld` pulse, with `st_code` set to the state just entered.
- R4: Falling test-clock edges, and changes on mode-select or the data pins while the clock is steady, do not change the state and give no report.
- R5: A data-in/data-out bit pair is recorded only on an edge whose old and new states are the same Shift state. The edge from Capture into Shift records nothing. The edges from Exit2 into Shift and from Shift into Exit1 also record nothing.
- R6: Recorded bits are packed so that the first one recorded is at bit 0 of `scan_tdi`/`scan_tdo`, the next at bit 1, and so on. Bits at or above `scan_len` are 0.
- R7: The edge from Shift-DR to Exit1-DR, or from Shift-IR to Exit1-IR, gives one single-cycle `scan_vld` pulse. The pulse comes with `scan_ir` (1 for instruction, 0 for data), `scan_len` and both vectors. The collectors then restart empty, so a scan of zero recorded bits reports length 0.
- R8: Entering Exit1 from Capture gives no scan report.
- R9: With `W` bits already held, further bits are dropped and the count stays at `W`. In that case `scan_ovf` is 1. A scan of exactly `W` bits has `scan_ovf` 0.
- R10: With the default two synchronizer stages, `st_vld` (and `scan_vld`) is high in the cycle after the third rising system-clock edge that samples the raw test clock high, and in no earlier cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the test clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_tck | input | 1 | Raw test clock |
| tap_tms | input | 1 | Raw mode select |
| tap_tdi | input | 1 | Raw data into the target |
| tap_tdo | input | 1 | Raw data out of the target |
| st_vld | output | 1 | State report strobe |
| st_code | output | 4 | Code of the state just entered |
| scan_vld | output | 1 | Scan report strobe |
| scan_ir | output | 1 | 1 = instruction scan, 0 = data scan |
| scan_len | output | $clog2(W+1) | Bits recorded, saturating at W |
| scan_ovf | output | 1 | Bits were dropped at the collector limit |
| scan_tdi | output | W | Data-in bits, first recorded at bit 0 |
| scan_tdo | output | W | Data-out bits, first recorded at bit 0 |

## Verification
A wrong tracked state shows on `st_code` at the very next test-clock rise, because every edge reports the state it enters. The error then spreads: a monitor stuck in the wrong branch will later miss the Exit1 flush, or report a scan with the wrong tag. A collector fault, such as a wrong write index, a missing clear or a bad saturation, stays hidden until the scan ends, and then appears as a wrong bit position, a stale high bit or a wrong length in the single `scan_vld` cycle. An error in the edge detector appears within one test-clock period as a missing or doubled `st_vld` pulse.

// File: rtl/tap_watch_pkg.sv
package tap_watch_pkg;

  typedef enum logic [3:0] {
    TS_RESET    = 4'd0,
    TS_IDLE     = 4'd1,
    TS_DR_SEL   = 4'd2,
    TS_DR_CAP   = 4'd3,
    TS_DR_UPD   = 4'd4,
    TS_DR_PAUSE = 4'd5,
    TS_DR_SHIFT = 4'd6,
    TS_DR_EX1   = 4'd7,
    TS_DR_EX2   = 4'd8,
    TS_IR_SEL   = 4'd9,
    TS_IR_CAP   = 4'd10,
    TS_IR_UPD   = 4'd11,
    TS_IR_PAUSE = 4'd12,
    TS_IR_SHIFT = 4'd13,
    TS_IR_EX1   = 4'd14,
    TS_IR_EX2   = 4'd15
  } tap_st_e;

  // Standard controller move for one rising test-clock edge.
  function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
    tap_st_e n;
    case (s)
      TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
      TS_IDLE:     n = m ? TS_DR_SEL   : TS_IDLE;
      TS_DR_SEL:   n = m ? TS_IR_SEL   : TS_DR_CAP;
      TS_DR_CAP:   n = m ? TS_DR_EX1   : TS_DR_SHIFT;
      TS_DR_SHIFT: n = m ? TS_DR_EX1   : TS_DR_SHIFT;
      TS_DR_EX1:   n = m ? TS_DR_UPD   : TS_DR_PAUSE;
      TS_DR_PAUSE: n = m ? TS_DR_EX2   : TS_DR_PAUSE;
      TS_DR_EX2:   n = m ? TS_DR_UPD   : TS_DR_SHIFT;
      TS_DR_UPD:   n = m ? TS_DR_SEL   : TS_IDLE;
      TS_IR_SEL:   n = m ? TS_RESET    : TS_IR_CAP;
      TS_IR_CAP:   n = m ? TS_IR_EX1   : TS_IR_SHIFT;
      TS_IR_SHIFT: n = m ? TS_IR_EX1   : TS_IR_SHIFT;
      TS_IR_EX1:   n = m ? TS_IR_UPD   : TS_IR_PAUSE;
      TS_IR_PAUSE: n = m ? TS_IR_EX2   : TS_IR_PAUSE;
      TS_IR_EX2:   n = m ? TS_IR_UPD   : TS_IR_SHIFT;
      TS_IR_UPD:   n = m ? TS_DR_SEL   : TS_IDLE;
      default:     n = TS_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic is_shift(input tap_st_e s);
    return (s == TS_DR_SHIFT) || (s == TS_IR_SHIFT);
  endfunction

  function automatic logic is_exit1(input tap_st_e s);
    return (s == TS_DR_EX1) || (s == TS_IR_EX1);
  endfunction

endpackage

// File: rtl/tap_watch_sync.sv
module tap_watch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tck_raw,
  input  logic tms_raw,
  input  logic tdi_raw,
  input  logic tdo_raw,
  output logic tck_rise,
  output logic tms_s,
  output logic tdi_s,
  output logic tdo_s
);
  localparam int NPIN = 4;
  localparam int LAST = STAGES - 1;

  logic [NPIN-1:0] raw;
  logic [STAGES-1:0][NPIN-1:0] stg;
  logic tck_prev;

  assign raw = {tdo_raw, tdi_raw, tms_raw, tck_raw};

  // Data flops carry no reset; they refill while rst is held.
  always_ff @(posedge clk) begin
    stg[0] <= raw;
    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
  end

  // Preset high so a clock already high at reset exit is not an edge.
  always_ff @(posedge clk) begin
    if (rst) tck_prev <= 1'b1;
    else     tck_prev <= stg[LAST][0];
  end

  assign tck_rise = stg[LAST][0] & ~tck_prev;
  assign tms_s    = stg[LAST][1];
  assign tdi_s    = stg[LAST][2];
  assign tdo_s    = stg[LAST][3];
endmodule

// File: rtl/tap_watch_fsm.sv
module tap_watch_fsm
  import tap_watch_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tck_rise,
  input  logic    tms,
  output tap_st_e cur_o,
  output tap_st_e nxt_o,
  output logic    st_vld_o,
  output logic [3:0] st_code_o
);
  tap_st_e cur_q;
  logic    seen_q;

  assign nxt_o = tap_next(cur_q, tms);
  assign cur_o = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q     <= TS_IDLE;
      seen_q    <= 1'b0;
      st_vld_o  <= 1'b0;
      st_code_o <= '0;
    end else begin
      st_vld_o <= 1'b0;
      if (tck_rise) begin
        cur_q  <= nxt_o;
        seen_q <= 1'b1;
        if (seen_q) begin
          st_vld_o  <= 1'b1;
          st_code_o <= nxt_o;
        end
      end
    end
  end
endmodule

// File: rtl/tap_watch_shift.sv
module tap_watch_shift
  import tap_watch_pkg::*;
#(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tck_rise,
  input  tap_st_e       cur,
  input  tap_st_e       nxt,
  input  logic          tdi,
  input  logic          tdo,
  output logic          scan_vld_o,
  output logic          scan_ir_o,
  output logic [CW-1:0] scan_len_o,
  output logic          scan_ovf_o,
  output logic [W-1:0]  scan_tdi_o,
  output logic [W-1:0]  scan_tdo_o
);
  logic [W-1:0]  acc_i, acc_o, wr_en;
  logic [CW-1:0] cnt_q;
  logic          ovf_q, rec, flush, full;

  assign rec   = tck_rise && is_shift(cur) && (nxt == cur);
  assign flush = tck_rise && is_shift(cur) && is_exit1(nxt);
  assign full  = (cnt_q == CW'(W));

  // One write strobe per slot: the slot equal to the current count.
  for (genvar g = 0; g < W; g++) begin : g_slot
    assign wr_en[g] = rec && !full && (cnt_q == CW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      acc_i <= '0;
      acc_o <= '0;
    end else begin
      for (int i = 0; i < W; i++) begin
        if (wr_en[i]) begin
          acc_i[i] <= tdi;
          acc_o[i] <= tdo;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (rec) begin
      if (full) ovf_q <= 1'b1;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_vld_o <= 1'b0;
      scan_ir_o  <= 1'b0;
      scan_len_o <= '0;
      scan_ovf_o <= 1'b0;
      scan_tdi_o <= '0;
      scan_tdo_o <= '0;
    end else begin
      scan_vld_o <= flush;
      if (flush) begin
        scan_ir_o  <= (cur == TS_IR_SHIFT);
        scan_len_o <= cnt_q;
        scan_ovf_o <= ovf_q;
        scan_tdi_o <= acc_i;
        scan_tdo_o <= acc_o;
      end
    end
  end
endmodule

// File: rtl/tap_watch.sv
module tap_watch
  import tap_watch_pkg::*;
#(
  parameter int W      = 64,
  parameter int STAGES = 2,
  parameter int CW     = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tap_tck,
  input  logic          tap_tms,
  input  logic          tap_tdi,
  input  logic          tap_tdo,
  output logic          st_vld,
  output logic [3:0]    st_code,
  output logic          scan_vld,
  output logic          scan_ir,
  output logic [CW-1:0] scan_len,
  output logic          scan_ovf,
  output logic [W-1:0]  scan_tdi,
  output logic [W-1:0]  scan_tdo
);
  logic    tck_rise, tms_s, tdi_s, tdo_s;
  tap_st_e cur_st, nxt_st;

  tap_watch_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .tck_raw(tap_tck), .tms_raw(tap_tms), .tdi_raw(tap_tdi), .tdo_raw(tap_tdo),
    .tck_rise(tck_rise), .tms_s(tms_s), .tdi_s(tdi_s), .tdo_s(tdo_s)
  );

  tap_watch_fsm u_fsm (
    .clk(clk), .rst(rst), .tck_rise(tck_rise), .tms(tms_s),
    .cur_o(cur_st), .nxt_o(nxt_st), .st_vld_o(st_vld), .st_code_o(st_code)
  );

  tap_watch_shift #(.W(W), .CW(CW)) u_shift (
    .clk(clk), .rst(rst), .tck_rise(tck_rise), .cur(cur_st), .nxt(nxt_st),
    .tdi(tdi_s), .tdo(tdo_s),
    .scan_vld_o(scan_vld), .scan_ir_o(scan_ir), .scan_len_o(scan_len),
    .scan_ovf_o(scan_ovf), .scan_tdi_o(scan_tdi), .scan_tdo_o(scan_tdo)
  );
endmodule

// File: rtl/tap_watch_chk.sv
module tap_watch_chk
  import tap_watch_pkg::*;
#(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          tck_rise,
  input tap_st_e       cur_st,
  input logic          st_vld,
  input logic [3:0]    st_code,
  input logic          scan_vld,
  input logic          scan_ir,
  input logic [CW-1:0] scan_len,
  input logic          scan_ovf
);
  p_rst_quiet_r1: assert property (@(posedge clk)
    rst |=> (!st_vld && !scan_vld));

  p_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    st_vld |=> !st_vld);

  p_after_rise_r3: assert property (@(posedge clk) disable iff (rst)
    st_vld |-> $past(tck_rise));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !tck_rise |=> $stable(cur_st));

  p_scan_exit_r7: assert property (@(posedge clk) disable iff (rst)
    scan_vld |-> (st_vld && ((scan_ir && st_code == TS_IR_EX1) ||
                             (!scan_ir && st_code == TS_DR_EX1))));

  p_scan_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    scan_vld |=> !scan_vld);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    scan_vld |-> ((scan_len <= CW'(W)) && (!scan_ovf || scan_len == CW'(W))));
endmodule

bind tap_watch tap_watch_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tck_rise(tck_rise), .cur_st(cur_st),
  .st_vld(st_vld), .st_code(st_code), .scan_vld(scan_vld),
  .scan_ir(scan_ir), .scan_len(scan_len), .scan_ovf(scan_ovf)
);

// File: tb/tap_watch_bench.sv
module tap_watch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 64;
  localparam int CW = $clog2(W + 1);

  typedef struct packed {
    logic tms, tdi, tdo, rep;
    logic [3:0] st;
    logic sc, ir;
    logic [7:0] len, vi, vo;
  } row_t;

  // Walk from Idle through a DR scan, a paused DR scan, an IR scan, reset.
  localparam row_t TBL [32] = '{
    '{1'b0,1'b0,1'b0,1'b0,4'd1 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b0,1'b1,4'd2 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b0,1'b0,1'b1,4'd3 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b1,1'b1,1'b1,4'd6 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b1,1'b0,1'b1,4'd6 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b0,1'b1,1'b1,4'd6 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b1,1'b1,1'b1,4'd6 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b0,1'b1,4'd7 ,1'b1,1'b0,8'd3,8'd5,8'd6},
    '{1'b0,1'b0,1'b0,1'b1,4'd5 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b1,1'b1,1'b1,4'd5 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b0,1'b1,4'd8 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b1,1'b1,1'b1,4'd6 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b1,1'b0,1'b1,4'd6 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b1,1'b1,4'd7 ,1'b1,1'b0,8'd1,8'd1,8'd0},
    '{1'b1,1'b0,1'b0,1'b1,4'd4 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b0,1'b1,4'd2 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b0,1'b1,4'd9 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b0,1'b0,1'b1,4'd10,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b1,1'b1,1'b1,1'b1,4'd14,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b0,1'b0,1'b1,4'd12,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b0,1'b1,4'd15,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b1,1'b1,1'b1,4'd13,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b0,1'b1,1'b1,4'd13,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b1,1'b1,1'b1,4'd13,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b1,1'b1,1'b0,1'b1,4'd14,1'b1,1'b1,8'd2,8'd2,8'd3},
    '{1'b1,1'b0,1'b0,1'b1,4'd11,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b0,1'b0,1'b1,4'd1 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b0,1'b1,4'd2 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b0,1'b1,4'd9 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b0,1'b1,4'd0 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b1,1'b0,1'b0,1'b1,4'd0 ,1'b0,1'b0,8'd0,8'd0,8'd0},
    '{1'b0,1'b0,1'b0,1'b1,4'd1 ,1'b0,1'b0,8'd0,8'd0,8'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tap_tck = 1'b0, tap_tms = 1'b0, tap_tdi = 1'b0, tap_tdo = 1'b0;
  logic st_vld, scan_vld, scan_ir, scan_ovf;
  logic [3:0] st_code;
  logic [CW-1:0] scan_len;
  logic [W-1:0] scan_tdi, scan_tdo;

  int n_chk = 0, n_fail = 0;
  int n_st = 0, n_sc = 0;
  logic [3:0] last_code;
  logic last_ir, last_ovf;
  logic [CW-1:0] last_len;
  logic [W-1:0] last_tdi, last_tdo;

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_watch #(.W(W)) u_tap_watch (
    .clk(clk), .rst(rst), .tap_tck(tap_tck), .tap_tms(tap_tms),
    .tap_tdi(tap_tdi), .tap_tdo(tap_tdo), .st_vld(st_vld), .st_code(st_code),
    .scan_vld(scan_vld), .scan_ir(scan_ir), .scan_len(scan_len),
    .scan_ovf(scan_ovf), .scan_tdi(scan_tdi), .scan_tdo(scan_tdo)
  );

  always @(negedge clk) begin
    if (st_vld) begin n_st++; last_code = st_code; end
    if (scan_vld) begin
      n_sc++; last_ir = scan_ir; last_len = scan_len; last_ovf = scan_ovf;
      last_tdi = scan_tdi; last_tdo = scan_tdo;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One full test-clock period; returns report pulses seen in it.
  task automatic step(input logic m, input logic di, input logic dout,
                      output int ds, output int dc);
    int s0, c0;
    tap_tck = 1'b0; tap_tms = m; tap_tdi = di; tap_tdo = dout;
    s0 = n_st; c0 = n_sc;
    repeat (4) @(negedge clk);
    tap_tck = 1'b1;
    repeat (4) @(negedge clk);
    ds = n_st - s0; dc = n_sc - c0;
  endtask

  task automatic go(input logic m);
    int ds, dc;
    step(m, 1'b0, 1'b0, ds, dc);
  endtask

  // Shift n bits from Idle into a DR scan and check the saturating result.
  task automatic long_scan(input int n);
    int ds, dc;
    logic [W-1:0] ei, eo;
    int keep;
    ei = '0; eo = '0;
    go(1'b1); go(1'b0); go(1'b0);
    for (int i = 0; i < n; i++) begin
      if (i < W) begin ei[i] = (i % 3 == 0); eo[i] = i[1]; end
      step(1'b0, (i % 3 == 0), i[1], ds, dc);
    end
    step(1'b1, 1'b0, 1'b0, ds, dc);
    keep = (n < W) ? n : W;
    chk(dc == 1, "R9 scan count", W'(dc), 1);
    chk(last_len == CW'(keep), "R9 saturated length", W'(last_len), W'(keep));
    chk(last_ovf == (n > W), "R9 overflow flag", W'(last_ovf), W'(n > W));
    chk(last_tdi == ei, "R6 long tdi vector", last_tdi, ei);
    chk(last_tdo == eo, "R6 long tdo vector", last_tdo, eo);
    go(1'b1); go(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ds, dc;
    repeat (5) @(negedge clk);
    chk(!st_vld && !scan_vld, "R1 strobes low in reset", W'({st_vld, scan_vld}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(scan_len == '0 && !scan_ovf, "R1 scan outputs cleared", W'(scan_len), 0);

    // Table walk: R1 on row 0, R2/R3 state, R5/R6/R7/R8 scans.
    for (int r = 0; r < 32; r++) begin
      step(TBL[r].tms, TBL[r].tdi, TBL[r].tdo, ds, dc);
      if (!TBL[r].rep) begin
        chk(ds == 0, "R1 first edge silent", W'(ds), 0);
      end else begin
        chk(ds == 1, "R3 one state pulse", W'(ds), 1);
        chk(last_code == TBL[r].st, "R2 state code", W'(last_code), W'(TBL[r].st));
      end
      if (TBL[r].sc) begin
        chk(dc == 1, "R7 scan pulse", W'(dc), 1);
        chk(last_ir == TBL[r].ir, "R7 scan tag", W'(last_ir), W'(TBL[r].ir));
        chk(last_len == CW'(TBL[r].len), "R5 scan length", W'(last_len), W'(TBL[r].len));
        chk(last_tdi == W'(TBL[r].vi), "R6 tdi order", last_tdi, W'(TBL[r].vi));
        chk(last_tdo == W'(TBL[r].vo), "R6 tdo order", last_tdo, W'(TBL[r].vo));
      end else begin
        chk(dc == 0, "R8 no scan here", W'(dc), 0);
      end
    end

    // R4: mode select flips while the clock is high; state must stay Idle.
    tap_tck = 1'b0; tap_tms = 1'b0;
    repeat (4) @(negedge clk);
    begin
      int s0;
      s0 = n_st;
      tap_tck = 1'b1;
      repeat (2) @(negedge clk);
      tap_tms = 1'b1; tap_tdi = 1'b1;
      repeat (6) @(negedge clk);
      tap_tck = 1'b0;
      repeat (8) @(negedge clk);
      chk(n_st - s0 == 1, "R4 one pulse, fall ignored", W'(n_st - s0), 1);
      chk(last_code == 4'd1, "R4 late tms ignored", W'(last_code), 1);
    end

    // R10: latency from raw rise to the state strobe.
    tap_tms = 1'b1;
    repeat (4) @(negedge clk);
    tap_tck = 1'b1;
    @(negedge clk); chk(!st_vld, "R10 no strobe at 1", W'(st_vld), 0);
    @(negedge clk); chk(!st_vld, "R10 no strobe at 2", W'(st_vld), 0);
    @(negedge clk); chk(st_vld && st_code == 4'd2, "R10 strobe at 3", W'(st_code), 2);
    @(negedge clk); chk(!st_vld, "R3 strobe one cycle", W'(st_vld), 0);
    go(1'b1); go(1'b1); go(1'b0);   // Select-IR, Reset, Idle

    // R9: exact fill then overflow.
    long_scan(W);
    long_scan(W + 6);

    // R1/R7: reset in mid-scan, then an empty scan reports length 0.
    go(1'b1); go(1'b0); go(1'b0);
    step(1'b0, 1'b1, 1'b1, ds, dc);
    step(1'b0, 1'b1, 1'b1, ds, dc);
    tap_tck = 1'b0; rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    step(1'b0, 1'b0, 1'b0, ds, dc);
    chk(ds == 0, "R1 first edge after reset silent", W'(ds), 0);
    step(1'b1, 1'b0, 1'b0, ds, dc);
    chk(last_code == 4'd2, "R1 reset state is Idle", W'(last_code), 2);
    go(1'b0); go(1'b0);
    step(1'b1, 1'b0, 1'b0, ds, dc);
    chk(dc == 1 && last_len == '0, "R7 empty scan length", W'(last_len), 0);
    chk(last_tdi == '0 && last_tdo == '0, "R7 collectors cleared", last_tdi | last_tdo, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule